// File: doc/BRIEF.md
# Window-Decoded Configuration Access Bridge

This bridge sits between a big-endian processor bus and a little-endian PCI configuration-space port. The processor reaches configuration registers by ordinary loads and stores into a fixed 4 MiB address window. Every access in that window becomes one configuration request. The target device is chosen by a one-hot select field in the processor address rather than by a binary device number.

The bridge scans address bits 11 to 21 upward. The position of the first set bit gives the device number, and a field with no bit set maps to device 11. The outgoing configuration address joins that device number with the low 11 address bits, which form the register offset. Sub-word data is right-justified on both 32-bit buses. Halfword and word data are byte-reversed in both directions, while byte data crosses unchanged.

Only one access is in flight at a time. An access outside the window is answered locally: no configuration request is issued, and a read returns all ones.

Top module: `cfg_window_bridge`

## Requirements
- R1: A configuration request (`cfg_valid_o` high) is raised only for accepted accesses whose address lies in 0x80800000..0x80BFFFFF (address bits 31:22 equal 0x202). It rises in the cycle after acceptance.
- R2: The device number is i (0..10) when address bit 11+i is the lowest set bit among bits 11..21. Higher set bits in that field are ignored.
- R3: When none of address bits 11..21 is set, the device number is 11.
- R4: `cfg_addr_o` is 15 bits wide. Bits 14:11 carry the device number and bits 10:0 copy processor address bits 10:0.
- R5: The size code is forwarded unchanged on `cfg_size_o`, as is the write flag on `cfg_we_o`. Size 0 is byte, 1 is halfword, 2 is word, and 3 is handled as word. Byte-write data passes through all 32 bits unchanged.
- R6: For a halfword write, `cfg_wdata_o` = {16'h0000, wdata[7:0], wdata[15:8]}.
- R7: For a word write (size 2 or 3), `cfg_wdata_o` holds the four bytes of `cpu_wdata_i` in reverse order.
- R8: Read data for an in-window access is taken when `cfg_valid_o` and `cfg_ready_i` are both high. It is returned as follows: unchanged for a byte read, as {16'h0000, d[7:0], d[15:8]} for a halfword read, and fully byte-reversed for a word read.
- R9: `cpu_ready_o` is low from the cycle after acceptance until `cpu_done_o` has pulsed. `cpu_done_o` is a one-cycle pulse that follows the configuration handshake by one cycle. `cpu_ready_o` returns high in the cycle after `cpu_done_o`.
- R10: While `cfg_valid_o` is high and `cfg_ready_i` is low, the configuration request (address, size, write flag, write data) holds stable.
- R11: An out-of-window access raises no configuration request. `cpu_done_o` pulses in the cycle after acceptance, with `cpu_rdata_o` equal to 0xFFFFFFFF.
- R12: After reset the bridge is idle: `cpu_ready_o` is 1, while `cfg_valid_o`, `cpu_done_o` and `cpu_rdata_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_valid_i | input | 1 | Processor access request |
| cpu_ready_o | output | 1 | Bridge idle, access accepted when valid is high |
| cpu_addr_i | input | 32 | Processor address |
| cpu_we_i | input | 1 | 1 for write, 0 for read |
| cpu_size_i | input | 2 | Access size code |
| cpu_wdata_i | input | 32 | Write data, big-endian, right-justified |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | 32 | Read data, valid with cpu_done_o |
| cfg_valid_o | output | 1 | Configuration request pending |
| cfg_ready_i | input | 1 | Configuration side completes request |
| cfg_addr_o | output | 15 | Device number and register offset |
| cfg_size_o | output | 2 | Access size code |
| cfg_we_o | output | 1 | Write flag |
| cfg_wdata_o | output | 32 | Write data, little-endian |
| cfg_rdata_i | input | 32 | Read data, valid with cfg_ready_i |

## Verification
On every cycle the assertions check the following: the handshake ordering, meaning a request one cycle after an in-window acceptance, completion one cycle after the configuration handshake, and ready withheld while a request is open. They also check that the request stays stable under back-pressure, that out-of-window accesses are answered locally with all ones, and that the offset and size are forwarded. The device-number priority, the empty-field case and the byte-lane reversal for each size and direction are shown only by the bench sweeps. Those sweeps step a single select bit across all eleven positions, add higher set bits to each, and run every size in both directions against arithmetically computed data.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRSV = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CFG  = 2'd1,
    ST_RESP = 2'd2
  } br_state_e;
endpackage

// File: rtl/cfg_win_decode.sv
module cfg_win_decode #(
  parameter int unsigned        ADDR_W   = 32,
  parameter logic [ADDR_W-1:0]  WIN_BASE = 32'h8080_0000,
  parameter int unsigned        WIN_LOG2 = 22,
  parameter int unsigned        SEL_LSB  = 11,
  parameter int unsigned        SEL_N    = 11,
  parameter int unsigned        DEV_W    = $clog2(SEL_N + 1),
  parameter int unsigned        CFG_AW   = SEL_LSB + DEV_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [CFG_AW-1:0] cfg_addr_o
);
  logic [SEL_N-1:0] sel;
  logic [SEL_N-1:0] sel_low;
  logic [DEV_W-1:0] dev;

  assign hit_o = (addr_i[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
  assign sel   = addr_i[SEL_LSB +: SEL_N];

  // isolate lowest set bit, then encode it
  assign sel_low = sel & (~sel + SEL_N'(1));

  always_comb begin
    dev = DEV_W'(SEL_N);
    for (int k = 0; k < int'(SEL_N); k++) begin
      if (sel_low[k]) dev = DEV_W'(k);
    end
  end

  assign cfg_addr_o = {dev, addr_i[SEL_LSB-1:0]};
endmodule

// File: rtl/cfg_byte_lane.sv
module cfg_byte_lane
  import cfg_bridge_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  acc_size_e         size_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned NB = DATA_W / 8;

  logic [DATA_W-1:0] word_rev;
  logic [DATA_W-1:0] half_sw;

  for (genvar b = 0; b < NB; b++) begin : g_rev
    assign word_rev[8*b +: 8] = data_i[8*(NB-1-b) +: 8];
  end

  assign half_sw = {{(DATA_W-16){1'b0}}, data_i[7:0], data_i[15:8]};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = data_i;
      SZ_HALF: data_o = half_sw;
      default: data_o = word_rev;
    endcase
  end
endmodule

// File: rtl/cfg_bridge_ctrl.sv
module cfg_bridge_ctrl
  import cfg_bridge_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpu_valid_i,
  input  logic hit_i,
  input  logic cfg_ready_i,
  output logic cpu_ready_o,
  output logic cfg_valid_o,
  output logic cpu_done_o,
  output logic accept_o,
  output logic cfg_fire_o
);
  br_state_e state_q, state_d;

  assign cpu_ready_o = (state_q == ST_IDLE);
  assign cfg_valid_o = (state_q == ST_CFG);
  assign cpu_done_o  = (state_q == ST_RESP);
  assign accept_o    = cpu_valid_i && cpu_ready_o;
  assign cfg_fire_o  = cfg_valid_o && cfg_ready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_o) state_d = hit_i ? ST_CFG : ST_RESP;
      ST_CFG:  if (cfg_ready_i) state_d = ST_RESP;
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/cfg_window_bridge.sv
module cfg_window_bridge
  import cfg_bridge_pkg::*;
#(
  parameter int unsigned        ADDR_W   = 32,
  parameter int unsigned        DATA_W   = 32,
  parameter logic [ADDR_W-1:0]  WIN_BASE = 32'h8080_0000,
  parameter int unsigned        WIN_LOG2 = 22,
  parameter int unsigned        SEL_LSB  = 11,
  parameter int unsigned        SEL_N    = 11,
  localparam int unsigned       DEV_W    = $clog2(SEL_N + 1),
  localparam int unsigned       CFG_AW   = SEL_LSB + DEV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_valid_i,
  output logic              cpu_ready_o,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_we_i,
  input  logic [1:0]        cpu_size_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cfg_valid_o,
  input  logic              cfg_ready_i,
  output logic [CFG_AW-1:0] cfg_addr_o,
  output logic [1:0]        cfg_size_o,
  output logic              cfg_we_o,
  output logic [DATA_W-1:0] cfg_wdata_o,
  input  logic [DATA_W-1:0] cfg_rdata_i
);
  logic              hit;
  logic              accept;
  logic              cfg_fire;
  logic [CFG_AW-1:0] dec_addr;
  logic [CFG_AW-1:0] caddr_q;
  acc_size_e         size_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_swapped;

  cfg_win_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2),
    .SEL_LSB(SEL_LSB), .SEL_N(SEL_N), .DEV_W(DEV_W), .CFG_AW(CFG_AW)
  ) u_dec (
    .addr_i     (cpu_addr_i),
    .hit_o      (hit),
    .cfg_addr_o (dec_addr)
  );

  cfg_bridge_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_valid_i (cpu_valid_i),
    .hit_i       (hit),
    .cfg_ready_i (cfg_ready_i),
    .cpu_ready_o (cpu_ready_o),
    .cfg_valid_o (cfg_valid_o),
    .cpu_done_o  (cpu_done_o),
    .accept_o    (accept),
    .cfg_fire_o  (cfg_fire)
  );

  cfg_byte_lane #(.DATA_W(DATA_W)) u_wr_lane (
    .size_i (size_q),
    .data_i (wdata_q),
    .data_o (cfg_wdata_o)
  );

  cfg_byte_lane #(.DATA_W(DATA_W)) u_rd_lane (
    .size_i (size_q),
    .data_i (cfg_rdata_i),
    .data_o (rd_swapped)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      caddr_q <= '0;
      size_q  <= SZ_BYTE;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      caddr_q <= dec_addr;
      size_q  <= acc_size_e'(cpu_size_i);
      we_q    <= cpu_we_i;
      wdata_q <= cpu_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_q <= '0;
    else if (accept && !hit)    rdata_q <= '1;
    else if (cfg_fire)          rdata_q <= rd_swapped;
  end

  assign cfg_addr_o  = caddr_q;
  assign cfg_size_o  = size_q;
  assign cfg_we_o    = we_q;
  assign cpu_rdata_o = rdata_q;
endmodule

// File: rtl/cfg_window_bridge_chk.sv
module cfg_window_bridge_chk #(
  parameter int unsigned        ADDR_W   = 32,
  parameter int unsigned        DATA_W   = 32,
  parameter logic [ADDR_W-1:0]  WIN_BASE = 32'h8080_0000,
  parameter int unsigned        WIN_LOG2 = 22,
  parameter int unsigned        SEL_LSB  = 11,
  parameter int unsigned        CFG_AW   = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_valid_i,
  input logic              cpu_ready_o,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_we_i,
  input logic [1:0]        cpu_size_i,
  input logic              cpu_done_o,
  input logic [DATA_W-1:0] cpu_rdata_o,
  input logic              cfg_valid_o,
  input logic              cfg_ready_i,
  input logic [CFG_AW-1:0] cfg_addr_o,
  input logic [1:0]        cfg_size_o,
  input logic              cfg_we_o,
  input logic [DATA_W-1:0] cfg_wdata_o
);
  logic acc, in_win;
  assign acc    = cpu_valid_i && cpu_ready_o;
  assign in_win = (cpu_addr_i[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);

  a_r1_req_after_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && in_win |=> cfg_valid_o);

  a_r4_offset_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && in_win |=> cfg_addr_o[SEL_LSB-1:0] == $past(cpu_addr_i[SEL_LSB-1:0]));

  a_r5_size_we_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && in_win |=> (cfg_size_o == $past(cpu_size_i)) && (cfg_we_o == $past(cpu_we_i)));

  a_r9_busy_while_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |-> !cpu_ready_o && !cpu_done_o);

  a_r9_done_after_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o && cfg_ready_i |=> cpu_done_o && !cfg_valid_o);

  a_r9_ready_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |=> cpu_ready_o && !cpu_done_o);

  a_r10_req_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o && !cfg_ready_i |=> cfg_valid_o && $stable(cfg_addr_o) && $stable(cfg_size_o)
      && $stable(cfg_we_o) && $stable(cfg_wdata_o));

  a_r11_miss_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !in_win |=> !cfg_valid_o && cpu_done_o && (cpu_rdata_o == '1));
endmodule

bind cfg_window_bridge cfg_window_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BASE(WIN_BASE),
  .WIN_LOG2(WIN_LOG2), .SEL_LSB(SEL_LSB), .CFG_AW(CFG_AW)
) u_chk (.*);

// File: tb/sim_cfg_window_bridge.sv
module sim_cfg_window_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0;
  logic        cpu_ready;
  logic [31:0] cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic [1:0]  cpu_size = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_done;
  logic [31:0] cpu_rdata;
  logic        cfg_valid;
  logic        cfg_ready = 1'b0;
  logic [14:0] cfg_addr;
  logic [1:0]  cfg_size;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata = '0;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  cfg_window_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_valid_i(cpu_valid), .cpu_ready_o(cpu_ready), .cpu_addr_i(cpu_addr),
    .cpu_we_i(cpu_we), .cpu_size_i(cpu_size), .cpu_wdata_i(cpu_wdata),
    .cpu_done_o(cpu_done), .cpu_rdata_o(cpu_rdata),
    .cfg_valid_o(cfg_valid), .cfg_ready_i(cfg_ready), .cfg_addr_o(cfg_addr),
    .cfg_size_o(cfg_size), .cfg_we_o(cfg_we), .cfg_wdata_o(cfg_wdata),
    .cfg_rdata_i(cfg_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_dev(input logic [31:0] a);
    for (int i = 0; i < 11; i++) if (a[11+i]) return 4'(i);
    return 4'd11;
  endfunction

  function automatic logic [31:0] exp_lane(input logic [1:0] sz, input logic [31:0] d);
    if (sz == 2'd0) return d;
    if (sz == 2'd1) return {16'h0000, d[7:0], d[15:8]};
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic access(input logic [31:0] a, input bit we, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [31:0] rd, input int stall);
    bit hit = (a[31:22] == 10'h202);
    logic [14:0] ea;
    logic [14:0] held;
    ea = {exp_dev(a), a[10:0]};
    @(negedge clk);
    cpu_valid = 1'b1; cpu_addr = a; cpu_we = we; cpu_size = sz; cpu_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    cpu_valid = 1'b0;
    if (hit) begin
      chk(cfg_valid === 1'b1, "R1", 32'(cfg_valid), 32'd1);
      chk(cfg_addr === ea, (exp_dev(a) == 4'd11) ? "R3" : "R2", 32'(cfg_addr), 32'(ea));
      chk(cfg_addr[10:0] === a[10:0], "R4", 32'(cfg_addr), 32'(ea));
      chk(cfg_size === sz && cfg_we === we, "R5", {cfg_size, 1'b0, cfg_we}, {sz, 1'b0, we});
      if (we)
        chk(cfg_wdata === exp_lane(sz, wd), (sz == 2'd0) ? "R5" : (sz == 2'd1) ? "R6" : "R7",
            cfg_wdata, exp_lane(sz, wd));
      chk(cpu_ready === 1'b0, "R9", 32'(cpu_ready), 32'd0);
      held = cfg_addr;
      for (int s = 0; s < stall; s++) begin
        @(posedge clk);
        @(negedge clk);
        chk(cfg_valid === 1'b1 && cfg_addr === held && cpu_ready === 1'b0 && cpu_done === 1'b0,
            "R10", 32'(cfg_addr), 32'(held));
      end
      cfg_ready = 1'b1; cfg_rdata = rd;
      @(posedge clk);
      @(negedge clk);
      cfg_ready = 1'b0;
      chk(cpu_done === 1'b1 && cfg_valid === 1'b0, "R9", 32'(cpu_done), 32'd1);
      if (!we) chk(cpu_rdata === exp_lane(sz, rd), "R8", cpu_rdata, exp_lane(sz, rd));
    end else begin
      chk(cfg_valid === 1'b0, "R1", 32'(cfg_valid), 32'd0);
      chk(cpu_done === 1'b1, "R11", 32'(cpu_done), 32'd1);
      if (!we) chk(cpu_rdata === 32'hFFFF_FFFF, "R11", cpu_rdata, 32'hFFFF_FFFF);
    end
    @(posedge clk);
    @(negedge clk);
    chk(cpu_ready === 1'b1 && cpu_done === 1'b0, "R9", {cpu_ready, cpu_done}, 32'd2);
  endtask

  task automatic check_idle();
    chk(cpu_ready === 1'b1 && cfg_valid === 1'b0 && cpu_done === 1'b0, "R12",
        {cpu_ready, cfg_valid, cpu_done}, 32'd4);
    chk(cpu_rdata === 32'h0, "R12", cpu_rdata, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle();
    rst_n = 1'b1;
    @(negedge clk);
    check_idle();

    // single select bit at every position (R2)
    for (int i = 0; i < 11; i++)
      access(32'h8080_0000 | (32'h1 << (11 + i)) | 32'(i * 4 + 3), 1'b0, 2'd2,
             32'h0, 32'h1122_3344 + 32'(i), i % 3);
    // lowest bit wins over higher set bits (R2)
    for (int i = 0; i < 11; i++)
      access(32'h8080_0000 | ((32'h003F_F800 << i) & 32'h003F_F800) | 32'h0000_0555,
             1'b1, 2'd2, 32'hA1B2_C3D4 ^ 32'(i), 32'h0, 0);
    // empty select field maps to device 11 (R3)
    access(32'h8080_07FC, 1'b0, 2'd1, 32'h0, 32'h0000_BEEF, 1);
    access(32'h8080_0000, 1'b1, 2'd0, 32'h0000_005A, 32'h0, 0);

    // size and direction sweep (R5 R6 R7 R8)
    for (int sz = 0; sz < 4; sz++) begin
      for (int w = 0; w < 2; w++) begin
        access(32'h8080_1010, w[0], 2'(sz), 32'hDEAD_BEEF, 32'hCAFE_F00D, 0);
        access(32'h80A0_0002, w[0], 2'(sz), 32'h0000_12EF, 32'h0000_A5C3, 2);
        access(32'h80BF_FFFF, w[0], 2'(sz), 32'h0102_0304, 32'h8070_6050, 0);
      end
    end

    // out-of-window, both sides of each boundary (R11 R1)
    access(32'h807F_FFFC, 1'b0, 2'd2, 32'h0, 32'h1234_5678, 0);
    access(32'h80C0_0000, 1'b0, 2'd1, 32'h0, 32'h1234_5678, 0);
    access(32'h0000_0000, 1'b1, 2'd2, 32'h5555_AAAA, 32'h0, 0);
    access(32'hFFFF_FFFF, 1'b0, 2'd0, 32'h0, 32'h0, 0);
    access(32'h8080_0000, 1'b0, 2'd2, 32'h0, 32'h0F0E_0D0C, 0);

    // reset in the middle of a pending request (R12)
    @(negedge clk);
    cpu_valid = 1'b1; cpu_addr = 32'h8080_0800; cpu_we = 1'b0; cpu_size = 2'd2;
    @(posedge clk);
    @(negedge clk);
    cpu_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check_idle();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle();
    access(32'h8090_0004, 1'b0, 2'd1, 32'h0, 32'h0000_3C4D, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule